// File: doc/BRIEF.md
# Integer ALU with Flag Update

This combinational unit forms the arithmetic and logic stage of a small load/store processor with 32-bit registers. The decode stage presents an operation code, the destination register value, the source register value, a 5-bit immediate field with its select bit, and the current carry flag. The unit returns the new destination value with a write strobe. It also returns new zero, carry, sign and overflow flag values, each with its own update strobe, so the flag register changes only the bits that the operation defines.

The operations are add and subtract, with and without carry or borrow, and compare. It also covers bitwise AND, OR, XOR and NOT, negate, increment and decrement, and fill-with-ones and fill-with-zeros. There are three shifts and four rotates, two of which pass through the carry. The bit operations clear, set, copy out to carry, or copy in from carry a single indexed bit. For shifts, rotates and bit operations, the count or bit index comes from the low 5 bits of the source register or from the immediate field.

Top module: `int_alu`

## Requirements
- R1: ADD (code 0) writes dest+src and ADC (code 1) writes dest+src+carry_in. Both update the carry to the carry out of bit 31, the overflow to signed two's-complement overflow, and the zero and sign flags.
- R2: SUB (code 2) writes dest-src and SBB (code 3) writes dest-src-carry_in. The carry becomes the borrow out of bit 31 and the overflow becomes signed overflow. CMP (code 4) updates all four flags as SUB does but never asserts res_we.
- R3: AND (5), OR (6), XOR (7) and NOT (19, the inverse of dest) write their result and update only the zero and sign flags. cf_we and of_we stay low.
- R4: SHR (8) fills the top with zeros, SAR (9) fills it with copies of bit 31, and SHL (10) fills the bottom with zeros. The carry takes the last bit shifted out: bit 0 for right moves and bit 31 for left moves.
- R5: ROR (11) and ROL (13) re-insert the bit that left the other end. RCR (12) and RCL (14) rotate through the carry, so the old carry enters the vacated end and the carry takes the last bit moved out.
- R6: For codes 8 to 18, the count or bit index is imm_val when use_imm is 1 and src_val[4:0] when use_imm is 0.
- R7: A shift or rotate with a count of zero writes dest unchanged and leaves cf_we low.
- R8: BCLR (15) and BSET (16) force the indexed bit of dest to 0 or 1. BXFER (18) writes carry_in into that bit. BTEST (17) copies that bit into the carry only, with res_we, zf_we, sf_we and of_we low.
- R9: NEG (20) writes the two's complement of dest and updates only the zero and sign flags. INC (21) and DEC (22) update the carry from the carry or borrow out of bit 31 and set the overflow equal to that carry.
- R10: SET (23) writes 0xFFFFFFFF with zf=0 and sf=1. CLR (24) writes 0 with zf=1 and sf=0. Neither updates the carry or overflow.
- R11: Every operation that writes a result sets zf when the result is zero and sets sf to result bit 31. Codes 25 to 31 assert no write strobe and no flag strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| dst_val | input | 32 | Destination operand |
| src_val | input | 32 | Source operand |
| imm_val | input | 5 | Immediate count or bit index |
| use_imm | input | 1 | 1 selects imm_val as count or index |
| carry_in | input | 1 | Current carry flag |
| res_out | output | 32 | Result value |
| res_we | output | 1 | Result write strobe |
| zf_out | output | 1 | New zero flag |
| zf_we | output | 1 | Zero flag update strobe |
| cf_out | output | 1 | New carry flag |
| cf_we | output | 1 | Carry flag update strobe |
| sf_out | output | 1 | New sign flag |
| sf_we | output | 1 | Sign flag update strobe |
| of_out | output | 1 | New overflow flag |
| of_we | output | 1 | Overflow flag update strobe |

## Verification
The immediate assertions assume the inputs are settled, known 2-state values whenever the logic evaluates. The bench therefore drives every input at once on a falling clock edge and never leaves one undriven. The assertions also assume that any 5-bit code is legal, so the random stimulus draws op_sel across all 32 codes, including the spares. Operand values are biased toward zero, all ones and the two sign boundaries, and counts are forced to zero in some vectors, so the carry, overflow and zero-count paths fire often.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBB  = 5'd3,
        OP_CMP   = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
        OP_SHR   = 5'd8,  OP_SAR  = 5'd9,  OP_SHL  = 5'd10, OP_ROR  = 5'd11,
        OP_RCR   = 5'd12, OP_ROL  = 5'd13, OP_RCL  = 5'd14, OP_BCLR = 5'd15,
        OP_BSET  = 5'd16, OP_BTEST = 5'd17, OP_BXFER = 5'd18, OP_NOT = 5'd19,
        OP_NEG   = 5'd20, OP_INC  = 5'd21, OP_DEC  = 5'd22, OP_SET  = 5'd23,
        OP_CLR   = 5'd24
    } alu_op_e;

    typedef struct packed {
        logic zf_we;
        logic cf_we;
        logic cf;
        logic sf_we;
        logic of_we;
        logic of;
    } flag_ctl_t;

    function automatic logic is_shift(input logic [4:0] code);
        return (code >= 5'd8) && (code <= 5'd14);
    endfunction

    function automatic logic is_logic(input logic [4:0] code);
        return (code >= 5'd5 && code <= 5'd7) || (code == 5'd19);
    endfunction

    function automatic logic uses_index(input logic [4:0] code);
        return (code >= 5'd8) && (code <= 5'd18);
    endfunction

endpackage

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_out,
    output logic             v_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   ext;
    logic [WIDTH-1:0] undo;

    always_comb begin
        if (do_sub) ext = {1'b0, a_in} - {1'b0, b_in} - {{WIDTH{1'b0}}, c_in};
        else        ext = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in};
        sum_out = ext[WIDTH-1:0];
        c_out   = ext[WIDTH];
        if (do_sub) v_out = (a_in[MSB] != b_in[MSB]) && (sum_out[MSB] != a_in[MSB]);
        else        v_out = (a_in[MSB] == b_in[MSB]) && (sum_out[MSB] != a_in[MSB]);
    end

    // reverse the operation and recover the first operand
    always_comb begin
        if (do_sub) undo = sum_out + b_in + {{(WIDTH-1){1'b0}}, c_in};
        else        undo = sum_out - b_in - {{(WIDTH-1){1'b0}}, c_in};
        AST_ADD_REVERSIBLE: assert (do_sub || undo == a_in);   // R1
        AST_SUB_REVERSIBLE: assert (!do_sub || undo == a_in);  // R2
    end

endmodule

// File: rtl/ialu_shifter.sv
module ialu_shifter
    import ialu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int CW = $clog2(WIDTH)
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] d_in,
    input  logic [CW-1:0]    cnt,
    input  logic             c_in,
    output logic [WIDTH-1:0] res,
    output logic             c_out
);
    logic [WIDTH:0]       one_ext;
    logic [2*WIDTH-1:0]   dbl;
    logic [2*WIDTH+1:0]   dbl_c;

    always_comb begin
        one_ext = '0;
        dbl     = '0;
        dbl_c   = '0;
        res     = d_in;
        c_out   = c_in;
        unique case (op)
            OP_SHR: begin
                one_ext = {d_in, c_in} >> cnt;
                res = one_ext[WIDTH:1];  c_out = one_ext[0];
            end
            OP_SAR: begin
                one_ext = $unsigned($signed({d_in, c_in}) >>> cnt);
                res = one_ext[WIDTH:1];  c_out = one_ext[0];
            end
            OP_SHL: begin
                one_ext = {c_in, d_in} << cnt;
                res = one_ext[WIDTH-1:0];  c_out = one_ext[WIDTH];
            end
            OP_ROR: begin
                dbl = {d_in, d_in} >> cnt;
                res = dbl[WIDTH-1:0];
                c_out = (cnt == '0) ? c_in : res[WIDTH-1];
            end
            OP_ROL: begin
                dbl = {d_in, d_in} << cnt;
                res = dbl[2*WIDTH-1:WIDTH];
                c_out = (cnt == '0) ? c_in : res[0];
            end
            OP_RCR: begin
                dbl_c = {c_in, d_in, c_in, d_in} >> cnt;
                res = dbl_c[WIDTH-1:0];  c_out = dbl_c[WIDTH];
            end
            OP_RCL: begin
                dbl_c = {c_in, d_in, c_in, d_in} << cnt;
                res = dbl_c[2*WIDTH:WIDTH+1];  c_out = dbl_c[2*WIDTH+1];
            end
            default: ;
        endcase
    end

    always_comb begin
        AST_ZERO_COUNT_HOLDS: assert (cnt != '0 || (res == d_in && c_out == c_in));  // R7
    end

endmodule

// File: rtl/ialu_bitfield.sv
module ialu_bitfield
    import ialu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int CW = $clog2(WIDTH)
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] d_in,
    input  logic [CW-1:0]    idx,
    input  logic             c_in,
    output logic [WIDTH-1:0] res,
    output logic             bit_out
);
    logic [WIDTH-1:0] sel;

    for (genvar i = 0; i < WIDTH; i++) begin : g_dec
        assign sel[i] = (idx == CW'(i));
    end

    assign bit_out = |(d_in & sel);

    always_comb begin
        unique case (op)
            OP_BCLR:  res = d_in & ~sel;
            OP_BSET:  res = d_in | sel;
            OP_BXFER: res = (d_in & ~sel) | (sel & {WIDTH{c_in}});
            default:  res = d_in;
        endcase
    end

    always_comb begin
        AST_ONE_BIT_TOUCHED: assert ($countones(res ^ d_in) <= 1);  // R8
    end

endmodule

// File: rtl/int_alu.sv
module int_alu
    import ialu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int CW = $clog2(WIDTH)
) (
    input  logic [4:0]       op_sel,
    input  logic [WIDTH-1:0] dst_val,
    input  logic [WIDTH-1:0] src_val,
    input  logic [CW-1:0]    imm_val,
    input  logic             use_imm,
    input  logic             carry_in,
    output logic [WIDTH-1:0] res_out,
    output logic             res_we,
    output logic             zf_out,
    output logic             zf_we,
    output logic             cf_out,
    output logic             cf_we,
    output logic             sf_out,
    output logic             sf_we,
    output logic             of_out,
    output logic             of_we
);
    alu_op_e          op;
    logic [CW-1:0]    count;
    logic [WIDTH-1:0] as_a, as_b, as_sum, sh_res, bf_res;
    logic             as_cin, as_sub, as_co, as_ov, sh_co, bf_bit;
    flag_ctl_t        fc;

    assign op    = alu_op_e'(op_sel);
    assign count = use_imm ? imm_val : src_val[CW-1:0];

    // operand steering into the shared adder
    always_comb begin
        as_a   = dst_val;
        as_b   = src_val;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC:         as_cin = carry_in;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB:         begin as_sub = 1'b1; as_cin = carry_in; end
            OP_INC:         begin as_b = '0; as_cin = 1'b1; end
            OP_DEC:         begin as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
            OP_NEG:         begin as_a = '0; as_b = dst_val; as_sub = 1'b1; end
            default: ;
        endcase
    end

    ialu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_in(as_a), .b_in(as_b), .c_in(as_cin), .do_sub(as_sub),
        .sum_out(as_sum), .c_out(as_co), .v_out(as_ov)
    );

    ialu_shifter #(.WIDTH(WIDTH)) u_shift (
        .op(op), .d_in(dst_val), .cnt(count), .c_in(carry_in),
        .res(sh_res), .c_out(sh_co)
    );

    ialu_bitfield #(.WIDTH(WIDTH)) u_bits (
        .op(op), .d_in(dst_val), .idx(count), .c_in(carry_in),
        .res(bf_res), .bit_out(bf_bit)
    );

    always_comb begin
        res_out = '0;
        res_we  = 1'b0;
        fc      = '0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                res_out = as_sum;
                res_we  = (op != OP_CMP);
                fc      = '{zf_we: 1'b1, cf_we: 1'b1, cf: as_co, sf_we: 1'b1, of_we: 1'b1, of: as_ov};
            end
            OP_INC, OP_DEC: begin
                res_out = as_sum;
                res_we  = 1'b1;
                fc      = '{zf_we: 1'b1, cf_we: 1'b1, cf: as_co, sf_we: 1'b1, of_we: 1'b1, of: as_co};
            end
            OP_NEG: begin
                res_out = as_sum;  res_we = 1'b1;  fc.zf_we = 1'b1;  fc.sf_we = 1'b1;
            end
            OP_AND: begin res_out = dst_val & src_val; res_we = 1'b1; fc.zf_we = 1'b1; fc.sf_we = 1'b1; end
            OP_OR:  begin res_out = dst_val | src_val; res_we = 1'b1; fc.zf_we = 1'b1; fc.sf_we = 1'b1; end
            OP_XOR: begin res_out = dst_val ^ src_val; res_we = 1'b1; fc.zf_we = 1'b1; fc.sf_we = 1'b1; end
            OP_NOT: begin res_out = ~dst_val;          res_we = 1'b1; fc.zf_we = 1'b1; fc.sf_we = 1'b1; end
            OP_SHR, OP_SAR, OP_SHL, OP_ROR, OP_RCR, OP_ROL, OP_RCL: begin
                res_out  = sh_res;
                res_we   = 1'b1;
                fc.zf_we = 1'b1;
                fc.sf_we = 1'b1;
                fc.cf_we = (count != '0);
                fc.cf    = sh_co;
            end
            OP_BCLR, OP_BSET, OP_BXFER: begin
                res_out = bf_res; res_we = 1'b1; fc.zf_we = 1'b1; fc.sf_we = 1'b1;
            end
            OP_BTEST: begin fc.cf_we = 1'b1; fc.cf = bf_bit; end
            OP_SET: begin res_out = '1; res_we = 1'b1; fc.zf_we = 1'b1; fc.sf_we = 1'b1; end
            OP_CLR: begin res_out = '0; res_we = 1'b1; fc.zf_we = 1'b1; fc.sf_we = 1'b1; end
            default: ;
        endcase
    end

    assign zf_out = (res_out == '0);
    assign sf_out = res_out[WIDTH-1];
    assign zf_we  = fc.zf_we;
    assign sf_we  = fc.sf_we;
    assign cf_we  = fc.cf_we;
    assign cf_out = fc.cf;
    assign of_we  = fc.of_we;
    assign of_out = fc.of;

    always_comb begin
        AST_CMP_NO_WRITE: assert (op_sel != 5'd4 || (!res_we && cf_we && of_we));     // R2
        AST_LOGIC_KEEPS_CO: assert (!is_logic(op_sel) || (!cf_we && !of_we));          // R3
        AST_SHIFT_ZERO_NO_CF: assert (!is_shift(op_sel) || count != '0 || !cf_we);     // R7
        AST_TEST_NO_WRITE: assert (op_sel != 5'd17 || (!res_we && cf_we && !zf_we));  // R8
        AST_INCDEC_OF_IS_CF: assert (!(op_sel == 5'd21 || op_sel == 5'd22) || of_out == cf_out);  // R9
        AST_SPARE_QUIET: assert (op_sel < 5'd25 ||
                                 !(res_we || zf_we || cf_we || sf_we || of_we));      // R11
        AST_INDEX_SOURCE: assert (!uses_index(op_sel) || !use_imm || count == imm_val); // R6
    end

endmodule

// File: tb/tb_int_alu.sv
module tb_int_alu;
    localparam int CLK_P  = 10;
    localparam int LIMIT  = 100000;
    localparam int NRAND  = 4000;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic [4:0]  op_sel;
    logic [31:0] dst_val, src_val;
    logic [4:0]  imm_val;
    logic        use_imm, carry_in;
    logic [31:0] res_out;
    logic        res_we, zf_out, zf_we, cf_out, cf_we, sf_out, sf_we, of_out, of_we;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    int_alu dut (
        .op_sel(op_sel), .dst_val(dst_val), .src_val(src_val), .imm_val(imm_val),
        .use_imm(use_imm), .carry_in(carry_in), .res_out(res_out), .res_we(res_we),
        .zf_out(zf_out), .zf_we(zf_we), .cf_out(cf_out), .cf_we(cf_we),
        .sf_out(sf_out), .sf_we(sf_we), .of_out(of_out), .of_we(of_we)
    );

    // reference model: returns {res, res_we, zf_we, zf, cf_we, cf, sf_we, sf, of_we, of}
    function automatic logic [40:0] model(input logic [4:0] op, input logic [31:0] d,
                                          input logic [31:0] s, input logic [4:0] imm,
                                          input logic ui, input logic c);
        logic [31:0] r = 32'd0;
        logic [32:0] t;
        logic wr = 1'b0, zs = 1'b0, cw = 1'b0, cv = 1'b0, ow = 1'b0, ov = 1'b0;
        logic [4:0] n = ui ? imm : s[4:0];
        logic tmp;
        case (op)
            5'd0, 5'd1: begin
                t = {1'b0, d} + {1'b0, s} + ((op == 5'd1) ? 33'(c) : 33'd0);
                r = t[31:0]; wr = 1; zs = 1; cw = 1; cv = t[32]; ow = 1;
                ov = (d[31] == s[31]) && (r[31] != d[31]);
            end
            5'd2, 5'd3, 5'd4: begin
                t = {1'b0, d} - {1'b0, s} - ((op == 5'd3) ? 33'(c) : 33'd0);
                r = t[31:0]; wr = (op != 5'd4); zs = 1; cw = 1; cv = t[32]; ow = 1;
                ov = (d[31] != s[31]) && (r[31] != d[31]);
            end
            5'd5:  begin r = d & s; wr = 1; zs = 1; end
            5'd6:  begin r = d | s; wr = 1; zs = 1; end
            5'd7:  begin r = d ^ s; wr = 1; zs = 1; end
            5'd19: begin r = ~d;    wr = 1; zs = 1; end
            5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd14: begin
                r = d; cv = c;
                for (int k = 0; k < int'(n); k++) begin
                    case (op)
                        5'd8:  begin cv = r[0];  r = {1'b0, r[31:1]}; end
                        5'd9:  begin cv = r[0];  r = {r[31], r[31:1]}; end
                        5'd10: begin cv = r[31]; r = {r[30:0], 1'b0}; end
                        5'd11: begin cv = r[0];  r = {r[0], r[31:1]}; end
                        5'd12: begin tmp = r[0]; r = {cv, r[31:1]}; cv = tmp; end
                        5'd13: begin cv = r[31]; r = {r[30:0], r[31]}; end
                        default: begin tmp = r[31]; r = {r[30:0], cv}; cv = tmp; end
                    endcase
                end
                wr = 1; zs = 1; cw = (n != 5'd0);
            end
            5'd15: begin r = d; r[n] = 1'b0; wr = 1; zs = 1; end
            5'd16: begin r = d; r[n] = 1'b1; wr = 1; zs = 1; end
            5'd18: begin r = d; r[n] = c;    wr = 1; zs = 1; end
            5'd17: begin cw = 1; cv = d[n]; end
            5'd20: begin r = ~d + 32'd1; wr = 1; zs = 1; end
            5'd21: begin t = {1'b0, d} + 33'd1; r = t[31:0]; wr = 1; zs = 1; cw = 1; cv = t[32]; ow = 1; ov = t[32]; end
            5'd22: begin t = {1'b0, d} - 33'd1; r = t[31:0]; wr = 1; zs = 1; cw = 1; cv = t[32]; ow = 1; ov = t[32]; end
            5'd23: begin r = 32'hFFFF_FFFF; wr = 1; zs = 1; end
            5'd24: begin r = 32'd0; wr = 1; zs = 1; end
            default: ;
        endcase
        return {wr ? r : 32'd0, wr, zs, zs & (r == 32'd0), cw, cw & cv, zs, zs & r[31], ow, ow & ov};
    endfunction

    function automatic string tag_of(input logic [4:0] op);
        if (op <= 5'd1) return "R1";
        if (op <= 5'd4) return "R2";
        if (op <= 5'd7 || op == 5'd19) return "R3";
        if (op <= 5'd10) return "R4";
        if (op <= 5'd14) return "R5";
        if (op <= 5'd18) return "R8";
        if (op <= 5'd22) return "R9";
        if (op <= 5'd24) return "R10";
        return "R11";
    endfunction

    task automatic apply(input logic [4:0] op, input logic [31:0] d, input logic [31:0] s,
                         input logic [4:0] imm, input logic ui, input logic c, input string tag);
        logic [40:0] exp_v, act_v;
        @(negedge clk);
        op_sel = op; dst_val = d; src_val = s; imm_val = imm; use_imm = ui; carry_in = c;
        #(CLK_P/4);
        exp_v = model(op, d, s, imm, ui, c);
        act_v = {res_we ? res_out : 32'd0, res_we, zf_we, zf_we & zf_out, cf_we, cf_we & cf_out,
                 sf_we, sf_we & sf_out, of_we, of_we & of_out};
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s op=%0d d=%h s=%h imm=%0d ui=%0b c=%0b actual=%h expected=%h",
                     tag, op, d, s, imm, ui, c, act_v, exp_v);
        end
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 6)
            0: return 32'd0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT && !done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        op_sel = 5'd31; dst_val = '0; src_val = '0; imm_val = '0; use_imm = 0; carry_in = 0;

        // idle code: nothing written (R11)
        apply(5'd31, 32'h1234_5678, 32'h1, 5'd3, 1'b1, 1'b1, "R11");
        apply(5'd25, 32'h0, 32'h0, 5'd0, 1'b0, 1'b0, "R11");
        // R1 carry out and overflow corners
        apply(5'd0, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b0, 1'b0, "R1");
        apply(5'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b0, 1'b0, "R1");
        apply(5'd1, 32'hFFFF_FFFE, 32'h1, 5'd0, 1'b0, 1'b1, "R1");
        // R2 borrow, compare
        apply(5'd3, 32'h0, 32'h0, 5'd0, 1'b0, 1'b1, "R2");
        apply(5'd4, 32'h55, 32'h55, 5'd0, 1'b0, 1'b0, "R2");
        apply(5'd2, 32'h8000_0000, 32'h1, 5'd0, 1'b0, 1'b0, "R2");
        // R3 logic leaves carry
        apply(5'd7, 32'hF0F0_F0F0, 32'hF0F0_F0F0, 5'd0, 1'b0, 1'b1, "R3");
        // R4 fills
        apply(5'd9, 32'h8000_0001, 32'h0, 5'd1, 1'b1, 1'b0, "R4");
        apply(5'd10, 32'h8000_0000, 32'h0, 5'd1, 1'b1, 1'b0, "R4");
        // R5 rotate through carry
        apply(5'd14, 32'h8000_0000, 32'h0, 5'd1, 1'b1, 1'b1, "R5");
        apply(5'd12, 32'h0000_0001, 32'h0, 5'd31, 1'b1, 1'b0, "R5");
        // R6 count source: imm vs register disagree
        apply(5'd8, 32'hFFFF_0000, 32'h0000_0010, 5'd4, 1'b1, 1'b0, "R6");
        apply(5'd8, 32'hFFFF_0000, 32'hFFFF_FFF0, 5'd4, 1'b0, 1'b0, "R6");
        // R7 zero count
        apply(5'd13, 32'hDEAD_BEEF, 32'h0, 5'd0, 1'b1, 1'b1, "R7");
        apply(5'd12, 32'hDEAD_BEEF, 32'hFFFF_FFE0, 5'd9, 1'b0, 1'b0, "R7");
        // R8 bit ops
        apply(5'd17, 32'h0000_0400, 32'h0, 5'd10, 1'b1, 1'b0, "R8");
        apply(5'd18, 32'h0, 32'h1F, 5'd0, 1'b0, 1'b1, "R8");
        apply(5'd15, 32'h0000_0400, 32'h0, 5'd10, 1'b1, 1'b1, "R8");
        // R9 inc/dec wrap, neg
        apply(5'd21, 32'hFFFF_FFFF, 32'h0, 5'd0, 1'b0, 1'b0, "R9");
        apply(5'd22, 32'h0, 32'h0, 5'd0, 1'b0, 1'b0, "R9");
        apply(5'd20, 32'h1, 32'h0, 5'd0, 1'b0, 1'b1, "R9");
        // R10 set / clear
        apply(5'd23, 32'h0, 32'h0, 5'd0, 1'b0, 1'b0, "R10");
        apply(5'd24, 32'hFFFF_FFFF, 32'h0, 5'd0, 1'b0, 1'b1, "R10");

        for (int i = 0; i < NRAND; i++) begin
            logic [4:0] op = 5'($urandom % 32);
            logic [4:0] imm = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            apply(op, pick(), pick(), imm, 1'($urandom), 1'($urandom), tag_of(op));
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule